// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a single-port synchronous static memory. Words are built from byte lanes; by default there are two 9-bit lanes, giving an 18-bit word. The address width is a parameter and sets the depth. On every rising edge the block samples its address, its two cycle-start strobes, three chip enables and the write controls.

A read registers the address on one edge. The word appears on the output register at the following edge. Bursts step through an aligned group of four words, in either linear or interleaved order. The advance input moves the burst on when no strobe is active.

The data bus is split into an input, an output and an output-enable. An enclosing pad or a test harness can turn these into a tri-state pin.

Top module: `sram_burst_top`

## Requirements
- R1: After reset, `dq_oe_o` is low and no cycle is in progress.
- R2: A processor strobe start (`adsp_n_i` low, all three chip enables low) loads `addr_i` and is always a read, whatever `adsc_n_i`, `gw_n_i`, `bwe_n_i`, `bw_n_i` and `dq_i` are. Memory is left unchanged.
- R3: While `ce0_n_i` is high, a low `adsp_n_i` is ignored: a running burst continues and `addr_i` is not loaded. A controller strobe on that edge is still decoded, and with any chip enable high it deselects.
- R4: A controller strobe (`adsc_n_i` low) acts only when no processor strobe is taken on the same edge. The write controls are sampled on that edge: with a write request, `dq_i` is written at `addr_i` on that edge; otherwise the cycle is a read.
- R5: Read data for an address registered at edge k is on `dq_o`, with `dq_oe_o` high (`oe_n_i` low), after edge k+1.
- R6: With `gw_n_i` low, every lane is written regardless of `bwe_n_i` and `bw_n_i`.
- R7: With `gw_n_i` high, lane j is written only when `bwe_n_i` and `bw_n_i[j]` are both low. Lane j is `dq[9j+8:9j]`.
- R8: The lane strobes are ignored on a processor strobe start edge. On later edges of that cycle with no strobe they write `dq_i` at the current burst address.
- R9: After any edge on which a write takes place, `dq_oe_o` is low for the next cycle, even with `oe_n_i` low.
- R10: A deselect taken during a read leaves the outputs driven for one more clock. They go high-impedance after the following edge.
- R11: With no strobe active and `adv_n_i` low, the two low address bits step through an aligned group of four. When `lin_burst_i` is high at the start, the order is linear ((base+n) mod 4); when it is low, the order is interleaved (base xor n). The upper address bits are held. `adv_n_i` is ignored on the start edge.
- R12: `oe_n_i` high forces `dq_oe_o` low at once, without changing the registered read data.
- R13: After a deselect, edges with no strobe start no cycle and do not change memory, even with write enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| adsp_n_i | input | 1 | Processor cycle-start strobe, active low |
| adsc_n_i | input | 1 | Controller cycle-start strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| ce0_n_i | input | 1 | Master chip enable, active low |
| ce1_n_i | input | 1 | Chip enable, active low |
| ce2_n_i | input | 1 | Chip enable, active low |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bw_n_i | input | LANES | Per-lane write strobes, active low |
| oe_n_i | input | 1 | Output enable, asynchronous, active low |
| lin_burst_i | input | 1 | Burst order at start: 1 linear, 0 interleaved |
| dq_i | input | LANE_W*LANES | Write data |
| dq_o | output | LANE_W*LANES | Registered read data |
| dq_oe_o | output | 1 | Output driver enable |

## Verification
The memory is first filled with global writes. It is then overwritten with seeded random mixes of global and lane writes, including byte-write-enable-high cases that must write nothing, and every word is read back; this separates correct lane masking from global override. Directed bursts from a base whose low bits are 01 tell linear order (5,6,7,4) from interleaved order (5,4,7,6), and would also expose an advance taken on the start edge. Further corner patterns cover a processor strobe with all write controls low, lane strobes on the start edge, a master-enable-blocked processor strobe during a burst, and both kinds of deselect. Together these separate read-only starts, ignored strobes and the one-clock driven tail.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE, OP_DESEL} op_e;

  typedef struct packed {
    op_e  op;      // start or deselect taken this edge
    logic cont;    // no strobe acts: burst continuation edge
    logic wr_req;  // write controls request a write
  } cmd_t;
endpackage

// File: rtl/sram_cmd_dec.sv
module sram_cmd_dec
  import sram_burst_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             adsp_n_i,
  input  logic             adsc_n_i,
  input  logic             ce0_n_i,
  input  logic             ce1_n_i,
  input  logic             ce2_n_i,
  input  logic             gw_n_i,
  input  logic             bwe_n_i,
  input  logic [LANES-1:0] bw_n_i,
  output cmd_t             cmd_o,
  output logic [LANES-1:0] lane_we_o
);
  logic adsp_hit, ctrl_sel, ce_ok, wr_req;

  assign ce_ok    = ~ce0_n_i & ~ce1_n_i & ~ce2_n_i;
  assign adsp_hit = ~adsp_n_i & ~ce0_n_i;   // master enable gates processor strobe only
  assign ctrl_sel = ~adsc_n_i & ~adsp_hit;
  assign wr_req   = ~gw_n_i | (~bwe_n_i & ~(&bw_n_i));

  for (genvar j = 0; j < LANES; j++) begin : g_we
    assign lane_we_o[j] = ~gw_n_i | (~bwe_n_i & ~bw_n_i[j]);
  end

  always_comb begin
    cmd_o.op     = OP_NONE;
    cmd_o.cont   = ~adsp_hit & adsc_n_i;
    cmd_o.wr_req = wr_req;
    if (adsp_hit)      cmd_o.op = ce_ok ? OP_READ : OP_DESEL;
    else if (ctrl_sel) cmd_o.op = !ce_ok ? OP_DESEL : (wr_req ? OP_WRITE : OP_READ);
  end
endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              lin_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q, low;
  logic              lin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      lin_q  <= 1'b1;
    end else if (load_i) begin
      base_q <= base_i;
      cnt_q  <= '0;
      lin_q  <= lin_i;
    end else if (adv_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign low    = lin_q ? base_q[CNT_W-1:0] + cnt_q : base_q[CNT_W-1:0] ^ cnt_q;
  assign addr_o = {base_q[ADDR_W-1:CNT_W], low};

  AST_BURST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && cnt_q == '1) |=> (cnt_q == '0)); // R11
  AST_BURST_UPPER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_o[ADDR_W-1:CNT_W])); // R11
endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LANE_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/sram_burst_top.sv
module sram_burst_top
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    adsp_n_i,
  input  logic                    adsc_n_i,
  input  logic                    adv_n_i,
  input  logic                    ce0_n_i,
  input  logic                    ce1_n_i,
  input  logic                    ce2_n_i,
  input  logic                    gw_n_i,
  input  logic                    bwe_n_i,
  input  logic [LANES-1:0]        bw_n_i,
  input  logic                    oe_n_i,
  input  logic                    lin_burst_i,
  input  logic [LANE_W*LANES-1:0] dq_i,
  output logic [LANE_W*LANES-1:0] dq_o,
  output logic                    dq_oe_o
);
  cmd_t              cmd;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] cur_addr, wr_addr;
  logic              start, cont_live, wr_fire;
  logic              active_q, rd_active_q, drv_q, wr_blk_q;

  sram_cmd_dec #(.LANES(LANES)) u_dec (
    .adsp_n_i (adsp_n_i),
    .adsc_n_i (adsc_n_i),
    .ce0_n_i  (ce0_n_i),
    .ce1_n_i  (ce1_n_i),
    .ce2_n_i  (ce2_n_i),
    .gw_n_i   (gw_n_i),
    .bwe_n_i  (bwe_n_i),
    .bw_n_i   (bw_n_i),
    .cmd_o    (cmd),
    .lane_we_o(lane_we)
  );

  assign start     = (cmd.op == OP_READ) || (cmd.op == OP_WRITE);
  assign cont_live = cmd.cont & active_q;
  // lane strobes only act on ADSC start or continuation edges
  assign wr_fire   = (cmd.op == OP_WRITE) | (cont_live & cmd.wr_req);
  assign wr_addr   = (cmd.op == OP_WRITE) ? addr_i : cur_addr;

  sram_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start),
    .base_i(addr_i),
    .lin_i (lin_burst_i),
    .adv_i (cont_live & ~adv_n_i),
    .addr_o(cur_addr)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_fire & lane_we[j]),
      .waddr_i(wr_addr),
      .wdata_i(dq_i[j*LANE_W +: LANE_W]),
      .re_i   (rd_active_q),
      .raddr_i(cur_addr),
      .rdata_o(dq_o[j*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      rd_active_q <= 1'b0;
      drv_q       <= 1'b0;
      wr_blk_q    <= 1'b0;
    end else begin
      if (start)                  active_q <= 1'b1;
      else if (cmd.op == OP_DESEL) active_q <= 1'b0;

      case (cmd.op)
        OP_READ:           rd_active_q <= 1'b1;
        OP_WRITE, OP_DESEL: rd_active_q <= 1'b0;
        default: if (cont_live && cmd.wr_req) rd_active_q <= 1'b0;
      endcase

      drv_q    <= rd_active_q;  // second deselect stage
      wr_blk_q <= wr_fire;
    end
  end

  assign dq_oe_o = ~oe_n_i & drv_q & ~wr_blk_q;

  AST_PROC_START_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.op == OP_READ) |=> (rd_active_q && !wr_blk_q)); // R2
  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.op == OP_READ) |-> ##2 drv_q); // R5
  AST_WRITE_HIDES_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> !dq_oe_o); // R9
  AST_DESEL_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.op == OP_DESEL && rd_active_q) |=> (drv_q && !rd_active_q)); // R10
  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && cmd.op == OP_NONE) |=> !active_q); // R13
endmodule

// File: tb/sram_burst_top_tb.sv
module sram_burst_top_tb;
  localparam int AW = 8;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int DW = LW * NL;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic          adsp_n, adsc_n, adv_n, ce0_n, ce1_n, ce2_n, gw_n, bwe_n, oe_n, lin;
  logic [NL-1:0] bw_n;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe;

  logic [DW-1:0] ref_mem [1<<AW];
  int  checks = 0, errors = 0;
  bit  done = 1'b0;

  sram_burst_top #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .adsp_n_i(adsp_n), .adsc_n_i(adsc_n),
    .adv_n_i(adv_n), .ce0_n_i(ce0_n), .ce1_n_i(ce1_n), .ce2_n_i(ce2_n), .gw_n_i(gw_n),
    .bwe_n_i(bwe_n), .bw_n_i(bw_n), .oe_n_i(oe_n), .lin_burst_i(lin), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1;
    ce0_n = 0; ce1_n = 0; ce2_n = 0;
    gw_n = 1; bwe_n = 1; bw_n = '1; oe_n = 0;
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w, input logic [DW-1:0] d,
                                          input logic gw, input logic bwe, input logic [NL-1:0] bw);
    merge = old_w;
    if (!gw) merge = d;
    else if (!bwe)
      for (int j = 0; j < NL; j++) if (!bw[j]) merge[j*LW +: LW] = d[j*LW +: LW];
  endfunction

  function automatic logic [AW-1:0] burst_addr(input logic [AW-1:0] base, input int n, input logic linear);
    logic [1:0] lo;
    lo = linear ? 2'(base[1:0] + 2'(n)) : (base[1:0] ^ 2'(n));
    burst_addr = {base[AW-1:2], lo};
  endfunction

  task automatic wr_ctrl(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic gw, input logic bwe, input logic [NL-1:0] bw);
    idle();
    addr = a; adsc_n = 0; dq_in = d; gw_n = gw; bwe_n = bwe; bw_n = bw;
    tick();
    ref_mem[a] = merge(ref_mem[a], d, gw, bwe, bw);
    if (!gw || (!bwe && bw != '1)) check("R9 write edge hides outputs", 18'(dq_oe), 18'(0));
    idle();
  endtask

  task automatic rd_single(input logic [AW-1:0] a, input string req);
    idle();
    addr = a; adsp_n = 0;
    tick();
    idle();
    tick();
    check(req, dq_out, ref_mem[a]);
    check("R5 driven one edge after address", 18'(dq_oe), 18'(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, junk;
    int seed;
    seed = $urandom(32'd1297);
    idle(); lin = 1; addr = '0; dq_in = '0; rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    check("R1 reset output disabled", 18'(dq_oe), 18'(0));

    // fill with global writes (bwe/bw random, must not matter)
    for (int i = 0; i < 32; i++)
      wr_ctrl(AW'(i), DW'($urandom), 1'b0, 1'($urandom), NL'($urandom));
    // random mix of global and lane writes
    for (int i = 0; i < 60; i++)
      wr_ctrl(AW'($urandom % 32), DW'($urandom), ($urandom % 4) != 0, 1'($urandom), NL'($urandom));
    for (int i = 0; i < 32; i++)
      rd_single(AW'(i), "R4 R6 R7 readback");

    // R2: processor start with every write control low is a read
    idle();
    addr = 3; adsp_n = 0; adsc_n = 0; gw_n = 0; bwe_n = 0; bw_n = '0;
    dq_in = ~ref_mem[3];
    tick(); idle(); tick();
    check("R2 processor start reads", dq_out, ref_mem[3]);
    rd_single(3, "R2 memory unchanged");

    // R8: lane strobes ignored on start edge, honoured after
    idle();
    addr = 9; adsp_n = 0; bwe_n = 0; bw_n = '0; dq_in = ~ref_mem[9];
    tick();
    idle();
    bwe_n = 0; bw_n = 2'b10; v = DW'($urandom); dq_in = v;
    tick();
    check("R9 continuation write hides outputs", 18'(dq_oe), 18'(0));
    ref_mem[9] = merge(ref_mem[9], v, 1'b1, 1'b0, 2'b10);
    idle(); tick();
    rd_single(9, "R8 only later lane strobe written");

    // R10 / R13: deselect tail, then idle writes ignored
    rd_single(12, "R10 setup read");
    adsc_n = 0; ce1_n = 1;
    tick();
    check("R10 driven one more clock", 18'(dq_oe), 18'(1));
    check("R10 data held in tail", dq_out, ref_mem[12]);
    idle(); tick();
    check("R10 high-impedance after tail", 18'(dq_oe), 18'(0));
    gw_n = 0; junk = ~ref_mem[12]; dq_in = junk;
    tick(); idle(); tick();
    rd_single(12, "R13 idle write has no effect");

    // R3: controller deselect with ce0 high while processor strobe low
    rd_single(13, "R3 setup read");
    adsp_n = 0; adsc_n = 0; ce0_n = 1;
    tick();
    check("R3 ce0-blocked edge deselects via controller strobe", 18'(dq_oe), 18'(1));
    idle(); tick();
    check("R3 high-impedance after controller deselect", 18'(dq_oe), 18'(0));

    // R3: blocked processor strobe does not restart burst
    idle();
    addr = 20; adsp_n = 0;
    tick();
    idle();
    adsp_n = 0; ce0_n = 1; addr = 28; adv_n = 0;
    tick();
    check("R3 first word", dq_out, ref_mem[20]);
    idle(); tick();
    check("R3 ADSP blocked by ce0_n, burst advanced", dq_out, ref_mem[21]);

    // R11: burst orders from base 5
    for (int m = 0; m < 2; m++) begin
      idle();
      lin = (m == 0); addr = 5; adsp_n = 0; adv_n = 0;
      tick();
      idle(); adv_n = 0;
      for (int n = 0; n < 4; n++) begin
        tick();
        check(m == 0 ? "R11 linear order" : "R11 interleaved order",
              dq_out, ref_mem[burst_addr(8'd5, n, m == 0)]);
      end
    end
    lin = 1;

    // R12: asynchronous output enable
    idle(); tick();
    v = dq_out;
    oe_n = 1; #1;
    check("R12 oe_n high disables at once", 18'(dq_oe), 18'(0));
    oe_n = 0; #1;
    check("R12 oe_n low re-enables", 18'(dq_oe), 18'(1));
    check("R12 data unchanged", dq_out, v);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule